// File: doc/BRIEF.md
# SD/MMC Command Line Issue Engine

This block is the host side of the command channel of an SD/MMC card interface. Software places a complete 48-bit command frame into three 16-bit frame words and then writes a fire word. The engine drives the frame onto the command line one bit per card clock, most significant bit first. It then releases the line and waits for the card's start bit. It captures either a 48-bit or a 136-bit response and raises completion flags in a status word.

Each fire word carries a request toggle bit. The engine copies that bit into the top bit of the status word only when the command finishes. Software therefore treats the completion flags as belonging to its own request only when the echoed bit equals the toggle it wrote. This way a status left over from the previous command can never be mistaken for the current one. Short responses are CRC7-checked unless the selected response kind skips the check. A configurable timeout bounds the wait for the card.

Top module: `sdc_cmd_engine`

## Requirements
- R1: After reset, `status` reads 0x0001 (only the idle flag, bit 0, set), `cmd_oe` is low and all response words are zero.
- R2: When `fire_valid` is sampled high while idle, the next cycle shows idle cleared with `cmd_oe` high. For the following 48 cycles `cmd_out` carries `{frame_hi, frame_mid, frame_lo}` starting from bit 15 of `frame_hi`.
- R3: A fire presented while not idle is ignored: neither the transmitted bits nor the echoed toggle change.
- R4: Response kind is taken from `fire_word[1:0]`: 0 none, 1 short with CRC check, 2 short without check, 3 long. With kind 0 the engine returns to idle right after the end bit, with the ready flag (bit 1) set and the response words unchanged.
- R5: The toggle bit in `fire_word[12]` appears in `status[15]` only at completion, at the same edge as the completion flags. While a command is in progress, `status[15]` keeps its previous value.
- R6: A short response of 48 bits is stored least significant bit first across words 0 to 2 of `resp_words`, so the 32-bit payload is {word2[7:0], word1, word0[15:8]}. Words 3 to 7 read zero.
- R7: A long response is 136 bits. Its first 8 received bits are dropped and the remaining 128 bits fill all eight words, with word 0 (bits 15:0) the least significant.
- R8: For kind 1, the CRC7 (x^7+x^3+1, zero start) of the first 40 response bits is compared with response bits 7:1, and a mismatch sets the CRC error flag (bit 3) alongside ready. Kinds 2 and 3 never set it.
- R9: Cycles are counted from the first cycle after the end bit. If the start bit (a 0 on `cmd_in`) is not seen within `tmo_cfg`×64 cycles, the timeout flag (bit 2) is set, ready stays clear and the response words keep their old value. A value of 0 times out at once.
- R10: `cmd_oe` is high only while the frame is being sent, and idle returns at every completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock, one command-line bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| fire_valid | input | 1 | Fire strobe, taken only while idle |
| fire_word | input | 16 | [1:0] response kind, [12] request toggle |
| frame_hi | input | 16 | Frame bytes 0 and 1 (sent first) |
| frame_mid | input | 16 | Frame bytes 2 and 3 |
| frame_lo | input | 16 | Frame bytes 4 and 5 (sent last) |
| tmo_cfg | input | 12 | Response timeout in units of 64 cycles |
| cmd_in | input | 1 | Command line as driven by the card |
| cmd_out | output | 1 | Command line value driven by the host |
| cmd_oe | output | 1 | Host drive enable for the command line |
| status | output | 16 | [0] idle, [1] ready, [2] timeout, [3] CRC error, [15] toggle echo |
| resp_words | output | 128 | Eight 16-bit response words, word 0 in bits 15:0 |

## Verification
A corrupted state register or bit counter shows up within one frame time. It appears as a wrong bit on `cmd_out` during the 48 transmit cycles, or as completion landing a cycle early or late against the card model's last response bit. Faults in the timeout counter appear exactly at the 64×N boundary: a start bit one cycle inside the window must be accepted and one cycle outside it must time out. A faulty CRC generator or capture register appears at completion as a wrong CRC flag or wrong words. A premature toggle echo is visible on `status[15]` during the transmit cycles.

// File: rtl/sdc_cmd_pkg.sv
package sdc_cmd_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_TX   = 2'd1,
      ST_WAIT = 2'd2,
      ST_RX   = 2'd3
   } eng_state_t;

   typedef enum logic [1:0] {
      RK_NONE      = 2'd0,
      RK_SHORT_CRC = 2'd1,
      RK_SHORT_RAW = 2'd2,
      RK_LONG      = 2'd3
   } resp_kind_t;

   localparam int STAT_IDLE = 0;
   localparam int STAT_RDY  = 1;
   localparam int STAT_TOUT = 2;
   localparam int STAT_CRC  = 3;
endpackage

// File: rtl/sdc_crc7.sv
module sdc_crc7 #(
   parameter int CRC_W = 7,
   parameter logic [CRC_W-1:0] POLY = 7'h09
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   input  logic             din,
   output logic [CRC_W-1:0] crc
);
   logic fb;
   assign fb = din ^ crc[CRC_W-1];

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         crc <= '0;
      end else if (en) begin
         crc <= {crc[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
      end
   end
endmodule

// File: rtl/sdc_tmo_cnt.sv
module sdc_tmo_cnt #(
   parameter int TMO_W         = 12,
   parameter int TMO_UNIT_LOG2 = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   input  logic [TMO_W-1:0] tmo,
   output logic             expired
);
   localparam int CNT_W = TMO_W + TMO_UNIT_LOG2;

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] limit;

   assign limit   = {tmo, {TMO_UNIT_LOG2{1'b0}}};
   assign expired = (cnt >= limit);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         cnt <= '0;
      end else if (en && !expired) begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/sdc_cmd_engine.sv
module sdc_cmd_engine
   import sdc_cmd_pkg::*;
#(
   parameter int WORD_W        = 16,
   parameter int FRAME_WORDS   = 3,
   parameter int LONG_W        = 136,
   parameter int HDR_W         = 8,
   parameter int TMO_W         = 12,
   parameter int TMO_UNIT_LOG2 = 6,
   parameter int CRC_SPAN      = 40,
   parameter int TOGGLE_BIT    = 12,
   parameter bit CHECK_CRC     = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      fire_valid,
   input  logic [WORD_W-1:0]         fire_word,
   input  logic [WORD_W-1:0]         frame_hi,
   input  logic [WORD_W-1:0]         frame_mid,
   input  logic [WORD_W-1:0]         frame_lo,
   input  logic [TMO_W-1:0]          tmo_cfg,
   input  logic                      cmd_in,
   output logic                      cmd_out,
   output logic                      cmd_oe,
   output logic [WORD_W-1:0]         status,
   output logic [LONG_W-HDR_W-1:0]   resp_words
);
   localparam int FRAME_W = WORD_W * FRAME_WORDS;
   localparam int STORE_W = LONG_W - HDR_W;
   localparam int CNT_W   = $clog2(LONG_W + 1);
   localparam logic [CNT_W-1:0] LAST_FRAME = CNT_W'(FRAME_W - 1);
   localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(LONG_W - 1);
   localparam logic [CNT_W-1:0] CRC_LIMIT  = CNT_W'(CRC_SPAN);

   if (FRAME_W != 48) begin : g_bad_frame
      $error("command frame must be 48 bits");
   end
   if (STORE_W % WORD_W != 0) begin : g_bad_store
      $error("stored response must be a whole number of words");
   end
   if (TOGGLE_BIT >= WORD_W - 1 || TOGGLE_BIT < 2) begin : g_bad_toggle
      $error("toggle bit must sit between kind field and echo bit");
   end
   if (CRC_SPAN + 8 != FRAME_W) begin : g_bad_span
      $error("CRC span must cover the frame minus CRC and end bit");
   end

   eng_state_t        state;
   resp_kind_t        kind_q;
   logic [FRAME_W-1:0] tx_sr;
   logic [LONG_W-1:0] rx_sr;
   logic [LONG_W-1:0] rx_next;
   logic [CNT_W-1:0]  bit_cnt;
   logic [TMO_W-1:0]  tmo_q;
   logic              tog_q;
   logic              idle_q, rdy_q, tout_q, crcerr_q, echo_q;
   logic [STORE_W-1:0] words_q;
   logic              tmo_expired;
   logic              crc_bad;
   logic              crc_clr, crc_en;
   logic              start_seen;
   logic [CNT_W-1:0]  rx_last;

   logic unused_inputs;
   assign unused_inputs = ^{fire_word, rx_sr[LONG_W-1]};

   assign rx_next    = {rx_sr[LONG_W-2:0], cmd_in};
   assign rx_last    = (kind_q == RK_LONG) ? LAST_LONG : LAST_FRAME;
   assign start_seen = (state == ST_WAIT) && !tmo_expired && !cmd_in;

   sdc_tmo_cnt #(
      .TMO_W        (TMO_W),
      .TMO_UNIT_LOG2(TMO_UNIT_LOG2)
   ) u_tmo (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (state != ST_WAIT),
      .en     (state == ST_WAIT),
      .tmo    (tmo_q),
      .expired(tmo_expired)
   );

   assign crc_clr = (state == ST_IDLE);
   assign crc_en  = start_seen || ((state == ST_RX) && (bit_cnt < CRC_LIMIT));

   if (CHECK_CRC) begin : g_crc
      logic [6:0] crc_val;
      sdc_crc7 u_crc (
         .clk  (clk),
         .rst_n(rst_n),
         .clr  (crc_clr),
         .en   (crc_en),
         .din  (cmd_in),
         .crc  (crc_val)
      );
      assign crc_bad = (crc_val != rx_next[7:1]);
   end else begin : g_nocrc
      logic unused_crc;
      assign unused_crc = crc_clr ^ crc_en;
      assign crc_bad    = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         kind_q   <= RK_NONE;
         tx_sr    <= '0;
         rx_sr    <= '0;
         bit_cnt  <= '0;
         tmo_q    <= '0;
         tog_q    <= 1'b0;
         idle_q   <= 1'b1;
         rdy_q    <= 1'b0;
         tout_q   <= 1'b0;
         crcerr_q <= 1'b0;
         echo_q   <= 1'b0;
         words_q  <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (fire_valid) begin
                  tx_sr    <= {frame_hi, frame_mid, frame_lo};
                  kind_q   <= resp_kind_t'(fire_word[1:0]);
                  tog_q    <= fire_word[TOGGLE_BIT];
                  tmo_q    <= tmo_cfg;
                  bit_cnt  <= '0;
                  idle_q   <= 1'b0;
                  rdy_q    <= 1'b0;
                  tout_q   <= 1'b0;
                  crcerr_q <= 1'b0;
                  state    <= ST_TX;
               end
            end
            ST_TX: begin
               tx_sr   <= {tx_sr[FRAME_W-2:0], 1'b0};
               bit_cnt <= bit_cnt + 1'b1;
               if (bit_cnt == LAST_FRAME) begin
                  if (kind_q == RK_NONE) begin
                     rdy_q  <= 1'b1;
                     idle_q <= 1'b1;
                     echo_q <= tog_q;
                     state  <= ST_IDLE;
                  end else begin
                     state <= ST_WAIT;
                  end
               end
            end
            ST_WAIT: begin
               if (tmo_expired) begin
                  tout_q <= 1'b1;
                  idle_q <= 1'b1;
                  echo_q <= tog_q;
                  state  <= ST_IDLE;
               end else if (!cmd_in) begin
                  rx_sr   <= '0;
                  bit_cnt <= CNT_W'(1);
                  state   <= ST_RX;
               end
            end
            ST_RX: begin
               rx_sr   <= rx_next;
               bit_cnt <= bit_cnt + 1'b1;
               if (bit_cnt == rx_last) begin
                  words_q  <= rx_next[STORE_W-1:0];
                  rdy_q    <= 1'b1;
                  crcerr_q <= (kind_q == RK_SHORT_CRC) && crc_bad;
                  idle_q   <= 1'b1;
                  echo_q   <= tog_q;
                  state    <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign cmd_oe     = (state == ST_TX);
   assign cmd_out    = (state == ST_TX) ? tx_sr[FRAME_W-1] : 1'b1;
   assign resp_words = words_q;

   always_comb begin
      status            = '0;
      status[STAT_IDLE] = idle_q;
      status[STAT_RDY]  = rdy_q;
      status[STAT_TOUT] = tout_q;
      status[STAT_CRC]  = crcerr_q;
      status[WORD_W-1]  = echo_q;
   end
endmodule

// File: rtl/sdc_cmd_engine_chk.sv
module sdc_cmd_engine_chk #(
   parameter int WORD_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              fire_valid,
   input logic              cmd_oe,
   input logic [WORD_W-1:0] status
);
   // R2: an accepted fire leaves idle and drives the line next cycle
   a_r2_fire_starts: assert property (@(posedge clk) disable iff (!rst_n)
      (fire_valid && status[0]) |=> (!status[0] && cmd_oe));

   // R10: the line is only driven while busy
   a_r10_oe_busy: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_oe |-> !status[0]);

   // R5: echo bit holds across busy cycles
   a_r5_echo_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!status[0] && !$past(status[0])) |-> $stable(status[WORD_W-1]));

   // R9: a timeout never coexists with ready and only shows when idle
   a_r9_tout_excl: assert property (@(posedge clk) disable iff (!rst_n)
      status[2] |-> (!status[1] && status[0]));

   // R8: a CRC error is reported only with a captured response
   a_r8_crc_with_rdy: assert property (@(posedge clk) disable iff (!rst_n)
      status[3] |-> status[1]);

   // R4: completion flags are only seen when idle
   a_r4_flags_idle: assert property (@(posedge clk) disable iff (!rst_n)
      status[1] |-> status[0]);
endmodule

bind sdc_cmd_engine sdc_cmd_engine_chk #(.WORD_W(WORD_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .fire_valid(fire_valid),
   .cmd_oe    (cmd_oe),
   .status    (status)
);

// File: tb/sdc_cmd_engine_test.sv
module sdc_cmd_engine_test;
   localparam int CLK_P = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         fire_valid = 1'b0;
   logic [15:0]  fire_word = '0;
   logic [15:0]  frame_hi = '0, frame_mid = '0, frame_lo = '0;
   logic [11:0]  tmo_cfg = '0;
   logic         cmd_in = 1'b1;
   logic         cmd_out, cmd_oe;
   logic [15:0]  status;
   logic [127:0] resp_words;

   int  checks = 0;
   int  errors = 0;
   bit  done = 1'b0;
   logic tog = 1'b0;
   logic [127:0] last_words = '0;

   always #(CLK_P/2) clk = ~clk;

   sdc_cmd_engine uut (
      .clk(clk), .rst_n(rst_n), .fire_valid(fire_valid), .fire_word(fire_word),
      .frame_hi(frame_hi), .frame_mid(frame_mid), .frame_lo(frame_lo),
      .tmo_cfg(tmo_cfg), .cmd_in(cmd_in), .cmd_out(cmd_out), .cmd_oe(cmd_oe),
      .status(status), .resp_words(resp_words)
   );

   // fields: kind[48:47] idx[46:41] arg[40:9] delay[8:1] corrupt[0]
   localparam logic [48:0] VEC [0:4] = '{
      {2'd1, 6'd17, 32'h0000_1200, 8'd3,  1'b0},
      {2'd1, 6'd13, 32'hDEAD_BEEF, 8'd0,  1'b1},
      {2'd2, 6'd41, 32'h00FF_8000, 8'd20, 1'b1},
      {2'd3, 6'd2,  32'h1234_5678, 8'd5,  1'b0},
      {2'd0, 6'd0,  32'h0000_0000, 8'd0,  1'b0}
   };

   task automatic check(input bit ok, input string req, input logic [127:0] act,
                        input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [6:0] crc7_40(input logic [39:0] d);
      logic [6:0] c;
      logic fb;
      c = '0;
      for (int i = 39; i >= 0; i--) begin
         fb = d[i] ^ c[6];
         c  = {c[5:0], 1'b0};
         if (fb) c = c ^ 7'h09;
      end
      return c;
   endfunction

   task automatic run_cmd(input logic [1:0] kind, input logic [5:0] idx,
                          input logic [31:0] arg, input int delay, input bit corrupt,
                          input logic [11:0] tmo, input bit exp_tout, input bit poke);
      logic [39:0]  fb, body;
      logic [47:0]  frame;
      logic [135:0] resp;
      logic [127:0] exp_words;
      logic [6:0]   c;
      int rlen, bad;
      fb    = {2'b01, idx, arg};
      frame = {fb, crc7_40(fb), 1'b1};
      tog   = ~tog;
      if (kind == 2'd3) begin
         exp_words = {arg, ~arg, arg ^ 32'h0F0F_0F0F, arg + 32'd1};
         resp      = {8'h3F, exp_words};
         rlen      = 136;
      end else begin
         body = {2'b00, idx, arg ^ 32'hA5A5_5A5A};
         c    = crc7_40(body);
         if (corrupt) c = c ^ 7'h01;
         resp      = {88'b0, body, c, 1'b1};
         exp_words = {80'b0, resp[47:0]};
         rlen      = 48;
      end
      @(negedge clk);
      frame_hi   = frame[47:32];
      frame_mid  = frame[31:16];
      frame_lo   = frame[15:0];
      fire_word  = 16'(kind) | (16'(tog) << 12);
      tmo_cfg    = tmo;
      fire_valid = 1'b1;
      @(negedge clk);
      fire_valid = 1'b0;
      check(status[0] == 1'b0 && cmd_oe, "R2 idle clear and line driven",
            128'({status[0], cmd_oe}), 128'b01);
      check(status[15] == ~tog, "R5 echo stale while busy", 128'(status[15]), 128'(~tog));
      bad = 0;
      for (int i = 0; i < 48; i++) begin
         if (poke && i == 10) begin
            fire_valid = 1'b1;
            frame_hi   = ~frame_hi;
            fire_word  = fire_word ^ 16'h1000;
         end
         if (poke && i == 11) fire_valid = 1'b0;
         if (!(cmd_oe && cmd_out == frame[47-i])) bad++;
         @(negedge clk);
      end
      check(bad == 0, "R2 frame bits MSB first", 128'(bad), 128'd0);
      if (poke) check(bad == 0, "R3 busy fire ignored", 128'(bad), 128'd0);
      if (kind == 2'd0) begin
         exp_words = last_words;
      end else begin
         check(!cmd_oe, "R10 line released after end bit", 128'(cmd_oe), 128'd0);
         for (int d = 0; d < delay; d++) @(negedge clk);
         if (exp_tout) begin
            @(negedge clk);
            exp_words = last_words;
         end else begin
            for (int b = rlen - 1; b >= 0; b--) begin
               cmd_in = resp[b];
               @(negedge clk);
            end
            cmd_in = 1'b1;
         end
      end
      check(status[0], "R10 idle at completion", 128'(status[0]), 128'd1);
      check(status[15] == tog, "R5 echo at completion", 128'(status[15]), 128'(tog));
      check(status[1] == !exp_tout, "R4 ready flag", 128'(status[1]), 128'(!exp_tout));
      check(status[2] == exp_tout, "R9 timeout flag", 128'(status[2]), 128'(exp_tout));
      check(status[3] == (kind == 2'd1 && corrupt && !exp_tout), "R8 crc flag",
            128'(status[3]), 128'(kind == 2'd1 && corrupt && !exp_tout));
      check(resp_words == exp_words,
            (kind == 2'd3) ? "R7 long words" : "R6 short words", resp_words, exp_words);
      last_words = resp_words;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(status == 16'h0001, "R1 reset status", 128'(status), 128'h1);
      check(!cmd_oe && cmd_out, "R1 line released", 128'({cmd_oe, cmd_out}), 128'b01);
      check(resp_words == '0, "R1 words zero", resp_words, '0);
      rst_n = 1'b1;
      for (int v = 0; v < 5; v++) begin
         run_cmd(VEC[v][48:47], VEC[v][46:41], VEC[v][40:9], int'(VEC[v][8:1]),
                 VEC[v][0], 12'd2, 1'b0, 1'b0);
      end
      // R9 boundary: last accepted slot, then first timed-out slot
      run_cmd(2'd1, 6'd8, 32'h0000_01AA, 63, 1'b0, 12'd1, 1'b0, 1'b0);
      run_cmd(2'd1, 6'd8, 32'h0000_01AA, 64, 1'b0, 12'd1, 1'b1, 1'b0);
      // R9 zero timeout expires immediately
      run_cmd(2'd2, 6'd5, 32'h0000_0000, 0, 1'b0, 12'd0, 1'b1, 1'b0);
      // R3 fire while busy, long response
      run_cmd(2'd3, 6'd9, 32'hCAFE_0001, 2, 1'b0, 12'd1, 1'b0, 1'b1);
      run_cmd(2'd0, 6'd0, 32'h0, 0, 1'b0, 12'd1, 1'b0, 1'b0);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule